// File: doc/BRIEF.md
# Rotate-and-Mask Datapath

This block is the shifter core of an integer execution unit. It rotates a 64-bit operand left by a 6-bit amount and then ANDs the rotated value with a mask. The mask is defined by a start boundary and a stop boundary. Bits are numbered big-endian, so bit 0 is the most significant bit and bit 63 is the least significant. When the start boundary lies past the stop boundary, the run of ones wraps through bit 63 and back to bit 0.

A word-mode select turns the unit into a 32-bit rotator. The low 32 bits of the operand are copied into both halves, and that 64-bit value is rotated. Each mask boundary is then read as its low five bits plus 32, so the mask covers the low word. The wrap rule still applies across all 64 bits.

The whole path is combinational. It exposes three outputs: the rotated value, the mask, and the masked result. Decode, the register file and any flag update are left to the surrounding pipeline.

Top module: `rot_mask_unit`

## Requirements
- R1: In doubleword mode (`word_mode_i`=0) with `mb_i` <= `me_i`, `mask_o` holds ones from big-endian bit `mb_i` to bit `me_i` inclusive and zeros elsewhere. Big-endian bit k is vector bit 63-k. Example: 37..63 gives 0x0000000007ffffff.
- R2: With start > stop, the mask holds ones from the start bit to bit 63 and from bit 0 to the stop bit. Example: 47,37 gives 0xfffffffffc01ffff.
- R3: With start equal to stop, the mask is a single one bit. Example: 32,32 gives 0x0000000080000000.
- R4: In word mode (`word_mode_i`=1), each effective boundary is 32 plus bits [4:0] of the boundary input. Bit 5 of `mb_i` and of `me_i` has no effect. Examples: 5,15 gives 0x0000000007ff0000, and 30,2 gives 0xffffffffe0000003.
- R5: In doubleword mode, `rot_o` is `src_i` rotated left by `amt_i` (0..63). Example: 0xdeadbeef12345678 by 10 gives 0xb6fbbc48d159e37a.
- R6: In word mode, `rot_o` is {`src_i`[31:0], `src_i`[31:0]} rotated left by `amt_i`, so both halves of the output are equal. `src_i`[63:32] has no effect. Example: 0xdeadbeef by 10 gives a low word of 0xb6fbbf7a.
- R7: `res_o` equals `rot_o` AND `mask_o` in both modes.
- R8: A rotate amount of 0 passes the rotator input through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Operand to rotate |
| amt_i | input | 6 | Left-rotate amount |
| word_mode_i | input | 1 | 1 selects the 32-bit word behaviour, 0 the 64-bit behaviour |
| mb_i | input | 6 | Mask start boundary (big-endian bit index) |
| me_i | input | 6 | Mask stop boundary (big-endian bit index) |
| rot_o | output | 64 | Rotated operand |
| mask_o | output | 64 | Generated mask |
| res_o | output | 64 | Rotated operand ANDed with the mask |

## Verification
There is no state, so a fault in the datapath shows on the ports in the same evaluation as the stimulus that exposes it.

- **Mask faults.** A wrong comparison or a missed wrap condition corrupts `mask_o` only for some boundary pairs. The bench therefore walks all 4096 doubleword pairs and all 1024 word-mode pairs.
- **Rotator faults.** A broken rotator stage shows only when its amount bit is set. The bench therefore sweeps every rotate amount against a shift-or model, on several operands.
- **Word-mode faults.** A fault in the copy of the low word into both halves shows as unequal halves of `rot_o`, or as leakage from the upper operand word.

// File: rtl/rm_pkg.sv
// Package: shared mode encoding and boundary mapping for the rotate-and-mask unit.
// Assumes boundaries are big-endian bit indices of a 64-bit datapath.
package rm_pkg;

    typedef enum logic {
        RM_DWORD = 1'b0,
        RM_WORD  = 1'b1
    } rm_mode_e;

    // Map a boundary to its effective 64-bit index; word mode uses 32 + low 5 bits.
    function automatic logic [5:0] rm_eff_bound(input logic [5:0] b, input logic word);
        return word ? {1'b1, b[4:0]} : b;
    endfunction

endpackage

// File: rtl/rm_spread.sv
// Module: rm_spread
// Builds the rotator input. In word mode the low half of the operand is
// copied into both halves; otherwise the operand passes unchanged.
// Assumes W is even.
module rm_spread #(
    parameter int W = 64
) (
    input  logic [W-1:0] src_i,
    input  logic         word_i,
    output logic [W-1:0] spread_o
);
    localparam int HALF = W / 2;

    // Select between doubled low half and full operand.
    always_comb begin
        spread_o = word_i ? {src_i[HALF-1:0], src_i[HALF-1:0]} : src_i;
    end
endmodule

// File: rtl/rm_rotator.sv
// Module: rm_rotator
// Logarithmic left rotator: stage k rotates by 2**k when amount bit k is set.
// Assumes W is a power of two and CW = log2(W), so the amount wraps modulo W.
module rm_rotator #(
    parameter int W  = 64,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  din_i,
    input  logic [CW-1:0] amt_i,
    output logic [W-1:0]  dout_o
);
    logic [W-1:0] stage [CW+1];

    // Feed stage 0 with the unrotated input.
    always_comb stage[0] = din_i;

    for (genvar k = 0; k < CW; k++) begin : g_stage
        localparam int SH = 1 << k;
        // Rotate by this stage's power of two when its amount bit is set.
        always_comb begin
            stage[k+1] = amt_i[k] ? {stage[k][W-1-SH:0], stage[k][W-1:W-SH]}
                                  : stage[k];
        end
    end

    // Last stage is the rotator output.
    always_comb dout_o = stage[CW];
endmodule

// File: rtl/rm_maskgen.sv
// Module: rm_maskgen
// Generates a big-endian mask of ones from start to stop, wrapping past the
// last bit when start > stop. STYLE 0 uses two shifted ones vectors combined by
// AND/OR; STYLE 1 uses a per-bit range compare. Both give the same result.
// Assumes W = 2**CW.
module rm_maskgen #(
    parameter int W     = 64,
    parameter int CW    = $clog2(W),
    parameter int STYLE = 0
) (
    input  logic [CW-1:0] start_i,
    input  logic [CW-1:0] stop_i,
    output logic [W-1:0]  mask_o
);
    logic wrap;

    // Wrap when start lies past stop.
    always_comb wrap = (start_i > stop_i);

    if (STYLE == 0) begin : g_shift
        logic [W-1:0] from_start;
        logic [W-1:0] to_stop;
        // Ones at big-endian index >= start, and ones at index <= stop.
        always_comb begin
            from_start = {W{1'b1}} >> start_i;
            to_stop    = ~(({W{1'b1}} >> stop_i) >> 1);
        end
        // Intersection for a plain run, union for a wrapped run.
        always_comb mask_o = wrap ? (from_start | to_stop) : (from_start & to_stop);
    end else begin : g_compare
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic ge_s, le_e;
            // Compare this big-endian index against both boundaries.
            always_comb begin
                ge_s = (CW'(i) >= start_i);
                le_e = (CW'(i) <= stop_i);
                mask_o[W-1-i] = wrap ? (ge_s | le_e) : (ge_s & le_e);
            end
        end
    end
endmodule

// File: rtl/rot_mask_unit.sv
// Module: rot_mask_unit
// Top of the rotate-and-mask datapath: spreads the operand (word mode),
// rotates it left, builds the mask from the effective boundaries and ANDs.
// Purely combinational; no clock or reset is needed.
module rot_mask_unit
    import rm_pkg::*;
#(
    parameter int W          = 64,
    parameter int MASK_STYLE = 0,
    localparam int CW        = $clog2(W)
) (
    input  logic [W-1:0]  src_i,
    input  logic [CW-1:0] amt_i,
    input  logic          word_mode_i,
    input  logic [CW-1:0] mb_i,
    input  logic [CW-1:0] me_i,
    output logic [W-1:0]  rot_o,
    output logic [W-1:0]  mask_o,
    output logic [W-1:0]  res_o
);
    rm_mode_e      mode;
    logic [W-1:0]  spread;
    logic [CW-1:0] mb_eff, me_eff;

    // Decode the mode select and map the boundaries for the chosen mode.
    always_comb begin
        mode   = rm_mode_e'(word_mode_i);
        mb_eff = rm_eff_bound(mb_i, mode == RM_WORD);
        me_eff = rm_eff_bound(me_i, mode == RM_WORD);
    end

    rm_spread #(.W(W)) u_spread (
        .src_i    (src_i),
        .word_i   (mode == RM_WORD),
        .spread_o (spread)
    );

    rm_rotator #(.W(W), .CW(CW)) u_rot (
        .din_i  (spread),
        .amt_i  (amt_i),
        .dout_o (rot_o)
    );

    rm_maskgen #(.W(W), .CW(CW), .STYLE(MASK_STYLE)) u_mask (
        .start_i (mb_eff),
        .stop_i  (me_eff),
        .mask_o  (mask_o)
    );

    // Apply the mask to the rotated value.
    always_comb res_o = rot_o & mask_o;
endmodule

// File: rtl/rot_mask_checks.sv
// Module: rot_mask_checks
// Property checks on the rotate-and-mask ports, attached by bind below.
// Assumes the datapath is combinational; checks run on every input change.
module rot_mask_checks #(
    parameter int W  = 64,
    parameter int CW = $clog2(W)
) (
    input logic [W-1:0]  src_i,
    input logic [CW-1:0] amt_i,
    input logic          word_mode_i,
    input logic [CW-1:0] mb_i,
    input logic [CW-1:0] me_i,
    input logic [W-1:0]  rot_o,
    input logic [W-1:0]  mask_o,
    input logic [W-1:0]  res_o
);
    localparam int HALF = W / 2;
    int s, e, ones_exp;

    // Mask population and rotator/result relations.
    always_comb begin
        s = word_mode_i ? (HALF + int'(mb_i[CW-2:0])) : int'(mb_i);
        e = word_mode_i ? (HALF + int'(me_i[CW-2:0])) : int'(me_i);
        ones_exp = (s <= e) ? (e - s + 1) : (W - s + e + 1);
        if (s < e)
            a_r1_run_len: assert ($countones(mask_o) == ones_exp)
                else $error("R1 mask popcount");
        if (s > e)
            a_r2_wrap_len: assert ($countones(mask_o) == ones_exp && mask_o[W-1] && mask_o[0])
                else $error("R2 wrap mask");
        if (s == e)
            a_r3_single: assert ($onehot0(mask_o) && mask_o != '0)
                else $error("R3 single bit");
        if (word_mode_i && s <= e)
            a_r4_low_word: assert (mask_o[W-1:HALF] == '0)
                else $error("R4 word mask leaks high");
        if (!word_mode_i)
            a_r5_popcount: assert ($countones(rot_o) == $countones(src_i))
                else $error("R5 rotate lost bits");
        if (word_mode_i)
            a_r6_halves: assert (rot_o[W-1:HALF] == rot_o[HALF-1:0]
                                 && $countones(rot_o[HALF-1:0]) == $countones(src_i[HALF-1:0]))
                else $error("R6 word halves");
        a_r7_subset: assert ((res_o & ~mask_o) == '0 && (res_o & ~rot_o) == '0)
            else $error("R7 result outside mask or rotate");
        if (amt_i == '0 && !word_mode_i)
            a_r8_pass: assert (rot_o == src_i)
                else $error("R8 zero rotate");
    end
endmodule

bind rot_mask_unit rot_mask_checks #(.W(W), .CW(CW)) u_checks (
    .src_i       (src_i),
    .amt_i       (amt_i),
    .word_mode_i (word_mode_i),
    .mb_i        (mb_i),
    .me_i        (me_i),
    .rot_o       (rot_o),
    .mask_o      (mask_o),
    .res_o       (res_o)
);

// File: tb/tb_rot_mask_unit.sv
module tb_rot_mask_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    typedef struct packed {
        logic        wm;
        logic [63:0] src;
        logic [5:0]  amt;
        logic [5:0]  mb;
        logic [5:0]  me;
        logic [63:0] exp_res;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'hffffffffffffffff, 6'd0,  6'd37, 6'd63, 64'h0000000007ffffff}, // R1
        '{1'b0, 64'hffffffffffffffff, 6'd0,  6'd47, 6'd37, 64'hfffffffffc01ffff}, // R2
        '{1'b0, 64'hffffffffffffffff, 6'd0,  6'd32, 6'd32, 64'h0000000080000000}, // R3
        '{1'b1, 64'hffffffffffffffff, 6'd0,  6'd5,  6'd15, 64'h0000000007ff0000}, // R4
        '{1'b1, 64'hffffffffffffffff, 6'd0,  6'd30, 6'd2,  64'hffffffffe0000003}, // R4 wrap
        '{1'b0, 64'hdeadbeef12345678, 6'd10, 6'd0,  6'd63, 64'hb6fbbc48d159e37a}, // R5
        '{1'b0, 64'hdeadbeef12345678, 6'd35, 6'd0,  6'd63, 64'h91a2b3c6f56df778}, // R5
        '{1'b1, 64'h00000000deadbeef, 6'd10, 6'd0,  6'd31, 64'h00000000b6fbbf7a}, // R6
        '{1'b1, 64'h00000000deadbeef, 6'd17, 6'd0,  6'd31, 64'h000000007ddfbd5b}, // R6
        '{1'b1, 64'hffffffff00000000, 6'd0,  6'd0,  6'd31, 64'h0000000000000000}, // R6 upper ignored
        '{1'b0, 64'hdeadbeef12345678, 6'd0,  6'd0,  6'd31, 64'hdeadbeef00000000}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src;
    logic [5:0]  amt, mb, me;
    logic        wm;
    logic [63:0] rot, mask, res;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    rot_mask_unit dut (
        .src_i(src), .amt_i(amt), .word_mode_i(wm), .mb_i(mb), .me_i(me),
        .rot_o(rot), .mask_o(mask), .res_o(res)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] ref_mask(input int s, input int e);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++) begin
            if ((s <= e) ? (i >= s && i <= e) : (i >= s || i <= e)) m[63-i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [63:0] ref_rotl(input logic [63:0] v, input int n);
        return (n == 0) ? v : ((v << n) | (v >> (64 - n)));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic w, input logic [63:0] s, input logic [5:0] a,
                         input logic [5:0] b, input logic [5:0] e);
        @(negedge clk);
        wm = w; src = s; amt = a; mb = b; me = e;
        #1;
    endtask

    initial begin
        wm = 1'b0; src = '0; amt = '0; mb = '0; me = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle state with all-zero inputs: single-bit mask at bit 0 (R3), zero data.
        check("R3 idle mask", mask, 64'h8000000000000000);
        check("R7 idle res", res, 64'h0);

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].wm, VECS[v].src, VECS[v].amt, VECS[v].mb, VECS[v].me);
            check($sformatf("R7 vector %0d", v), res, VECS[v].exp_res);
        end

        // R1 R2 R3: all doubleword boundary pairs against the reference loop.
        for (int b = 0; b < 64; b++)
            for (int e = 0; e < 64; e++) begin
                apply(1'b0, 64'hffffffffffffffff, 6'd0, 6'(b), 6'(e));
                check(b < e ? "R1 mask" : (b > e ? "R2 mask" : "R3 mask"), mask, ref_mask(b, e));
            end

        // R4: word-mode pairs, bit 5 of the boundaries set to show it is ignored.
        for (int b = 0; b < 32; b++)
            for (int e = 0; e < 32; e++) begin
                apply(1'b1, 64'h0123456789abcdef, 6'd0, 6'(b) | 6'h20 * 6'(b & 1), 6'(e) | 6'h20);
                check("R4 word mask", mask, ref_mask(32 + b, 32 + e));
            end

        // R5 R8: every rotate amount on several operands against the shift-or model.
        for (int p = 0; p < 3; p++) begin
            logic [63:0] op = (p == 0) ? 64'hdeadbeef12345678 :
                              (p == 1) ? 64'h8000000000000001 : 64'h0f1e2d3c4b5a6978;
            for (int n = 0; n < 64; n++) begin
                apply(1'b0, op, 6'(n), 6'd0, 6'd63);
                check(n == 0 ? "R8 pass-through" : "R5 rotate", rot, ref_rotl(op, n));
                check("R7 full mask", res, rot & 64'hffffffffffffffff);
            end
        end

        // R6: word-mode rotate with junk in the upper word.
        for (int n = 0; n < 64; n++) begin
            apply(1'b1, 64'hcafef00ddeadbeef & 64'hffffffffffffffff, 6'(n), 6'd0, 6'd31);
            check("R6 word rotate", rot, ref_rotl({32'hdeadbeef, 32'hdeadbeef}, n));
            check("R7 word result", res, {32'h0, rot[31:0]});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule